// File: doc/BRIEF.md
# Prioritised Data-Frame Serializer for a Dominant-Zero Shared Bus

This block sends one classic base-format data frame onto a single-wire bus where every node drives through a wired-AND. A zero is the dominant level and a one is the recessive level. The bus rests recessive, and any node that pulls low wins that bit. A request carries an 11-bit identifier, a 4-bit length code and up to eight payload bytes. The block then sends the frame bit by bit. It adds the stuffed bits and the 15-bit check sequence, and it reads the bus back on every bit. While the identifier is being sent, it withdraws as soon as it loses the bus to a node with a lower identifier.

The block moves only when a one-cycle bit strobe arrives from an outside bit-timing unit. It samples the bus level at the strobe that closes each bit. The receive path, error signalling and the analog transceiver are built elsewhere.

Top module: `can_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `bus_tx` is 1 (recessive) and `busy` is 0.
- R2: `start` is acted on only at a `bit_tick` while idle, and only after `bus_rx` has been 1 at `IFS_BITS` (default 3) consecutive strobes. A strobe that sees `bus_rx`=0 restarts that count. When a start is accepted, `busy` rises and `bus_tx` drives the start-of-frame bit, which is 0.
- R3: The unstuffed frame runs in this order: start-of-frame 0, identifier bits 10 down to 0, three 0 bits (data-frame, base-format, reserved), length code bits 3 down to 0, then the payload. The payload is min(length,8) bytes taken from `payload[63:56]` onward, each byte MSB first. A length code above 8 is sent as given but carries 8 bytes.
- R4: After the payload comes a 15-bit check sequence, MSB first, followed by one recessive delimiter. The sequence uses generator 0x4599 with an all-zero initial value, and it runs over the unstuffed bits from start-of-frame through the last payload bit.
- R5: From start-of-frame through the last check-sequence bit, every run of five equal bits on the wire is followed by one bit of the opposite level. This includes a run that ends on the last check bit. Stuffed bits count toward the next run.
- R6: If an identifier bit is sent as 1 and `bus_rx` reads 0 at the strobe that closes it, `arb_lost` pulses for one clock. In that same clock `bus_tx` returns to 1, `busy` falls, and `done` never pulses for that frame.
- R7: The ACK slot and the ACK delimiter are both driven 1. If `bus_rx` reads 1 at the strobe that closes the slot, `ack_miss` pulses for one clock and the frame still runs to its end.
- R8: After the ACK delimiter come seven recessive end bits and `IFS_BITS` recessive gap bits, with no stuffing. At the strobe that closes the last gap bit, `done` pulses for one clock and `busy` falls.
- R9: `bus_tx` changes only in the clock after a `bit_tick`. With no strobe, the frame holds its position however long the wait.
- R10: `start` has no effect while `busy` is 1. The frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe at each bit boundary |
| start | input | 1 | Request to send a frame |
| ident | input | 11 | Frame identifier; lower value has higher priority |
| dlc | input | 4 | Length code |
| payload | input | 64 | Payload bytes, first byte in bits 63:56 |
| bus_rx | input | 1 | Sampled bus level |
| bus_tx | output | 1 | Level this node drives (1 = released) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse when the frame and its gap are finished |
| arb_lost | output | 1 | One-clock pulse when the bus is lost to another node |
| ack_miss | output | 1 | One-clock pulse when no node acknowledged |

## Verification
Most internal faults change the wire sequence. A wrong field counter, shift position or check-sequence register moves or flips a bit on `bus_tx` within one bit time of the fault. A broken run counter shows up at the next fifth equal bit. So the bench compares every bit of each frame against a model built from R3 to R5. It also watches the strobe that must raise `arb_lost`, `ack_miss` or `done`, because a wrong state in the tail or arbitration logic either moves these pulses by whole bits or removes them.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int ID_W  = 11;
  localparam int LEN_W = 4;
  localparam int CRC_W = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
  localparam int EOF_BITS = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BODY, ST_CRC, ST_CRCDEL, ST_ACK,
    ST_ACKDEL, ST_EOF, ST_IFS, ST_FIN
  } tx_state_t;
endpackage

// File: rtl/can_tx_crc.sv
module can_tx_crc
  import can_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic upd,
  input  logic shift,
  input  logic bit_in,
  output logic msb
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb  = bit_in ^ crc_q[CRC_W-1];
  assign msb = crc_q[CRC_W-1];

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= '0;
    else if (upd)   crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    else if (shift) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  // R4: the register is either cleared, fed or drained, never two at once
  assert_crc_ops_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr, upd, shift}));
endmodule

// File: rtl/can_tx_stuff.sv
module can_tx_stuff #(
  parameter int RUN_MAX = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic upd,
  input  logic bit_in,
  output logic hit
);
  localparam int RUN_W = $clog2(RUN_MAX + 1);
  logic [RUN_W-1:0] run_q;
  logic             last_q;

  assign hit = (bit_in == last_q) && (run_q == RUN_W'(RUN_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (upd) begin
      last_q <= bit_in;
      run_q  <= (bit_in == last_q) ? run_q + 1'b1 : RUN_W'(1);
    end
  end

  // R5: a counted bit never extends a run that already holds RUN_MAX
  assert_run_limit_R5: assert property (@(posedge clk) disable iff (rst)
    (upd && !restart && bit_in == last_q) |-> (run_q < RUN_W'(RUN_MAX)));
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int IFS_BITS  = 3,
  parameter int STUFF_RUN = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bit_tick,
  input  logic                   start,
  input  logic [ID_W-1:0]        ident,
  input  logic [LEN_W-1:0]       dlc,
  input  logic [8*MAX_BYTES-1:0] payload,
  input  logic                   bus_rx,
  output logic                   bus_tx,
  output logic                   busy,
  output logic                   done,
  output logic                   arb_lost,
  output logic                   ack_miss
);
  localparam int HDR_BITS = ID_W + 3 + LEN_W;
  localparam int SH_W     = HDR_BITS + 8*MAX_BYTES;
  localparam int CNT_MAX  = (SH_W > CRC_W + EOF_BITS + IFS_BITS) ? SH_W : CRC_W + EOF_BITS + IFS_BITS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int GAP_W    = $clog2(IFS_BITS + 1);
  localparam int ARB_W    = $clog2(ID_W + 1);

  tx_state_t        state;
  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] cnt;
  logic [GAP_W-1:0] idle_cnt;
  logic [ARB_W-1:0] arb_left;
  logic             cur_arb, cur_ack;
  logic             accept, lost, region, stuff_hit, need_stuff, crc_msb;
  logic [LEN_W-1:0] nbytes;

  assign nbytes     = (dlc > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : dlc;
  assign accept     = bit_tick && state == ST_IDLE && start && idle_cnt == GAP_W'(IFS_BITS);
  assign lost       = cur_arb && bus_tx && !bus_rx;
  assign region     = state == ST_BODY || state == ST_CRC || state == ST_CRCDEL;
  assign need_stuff = region && stuff_hit;

  can_tx_crc u_crc (
    .clk(clk), .rst(rst), .clr(accept),
    .upd(bit_tick && state == ST_BODY && !need_stuff && !lost),
    .shift(bit_tick && state == ST_CRC && !need_stuff),
    .bit_in(sh[SH_W-1]), .msb(crc_msb)
  );

  can_tx_stuff #(.RUN_MAX(STUFF_RUN)) u_stuff (
    .clk(clk), .rst(rst), .restart(accept),
    .upd(bit_tick && region && !lost),
    .bit_in(bus_tx), .hit(stuff_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bus_tx   <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      arb_lost <= 1'b0;
      ack_miss <= 1'b0;
      sh       <= '0;
      cnt      <= '0;
      idle_cnt <= '0;
      arb_left <= '0;
      cur_arb  <= 1'b0;
      cur_ack  <= 1'b0;
    end else begin
      done     <= 1'b0;
      arb_lost <= 1'b0;
      ack_miss <= 1'b0;
      if (bit_tick) begin
        if (!bus_rx)                            idle_cnt <= '0;
        else if (idle_cnt != GAP_W'(IFS_BITS))  idle_cnt <= idle_cnt + 1'b1;
        if (state == ST_IDLE) begin
          if (accept) begin
            bus_tx   <= 1'b0;
            busy     <= 1'b1;
            sh       <= {ident, 3'b000, dlc, payload};
            cnt      <= CNT_W'(HDR_BITS) + CNT_W'({nbytes, 3'b000});
            arb_left <= ARB_W'(ID_W);
            cur_arb  <= 1'b0;
            cur_ack  <= 1'b0;
            state    <= ST_BODY;
          end
        end else if (lost) begin
          bus_tx   <= 1'b1;
          busy     <= 1'b0;
          arb_lost <= 1'b1;
          cur_arb  <= 1'b0;
          state    <= ST_IDLE;
        end else begin
          if (cur_ack && bus_rx) ack_miss <= 1'b1;
          cur_ack <= 1'b0;
          cur_arb <= 1'b0;
          if (need_stuff) begin
            bus_tx <= ~bus_tx;
          end else begin
            case (state)
              ST_BODY: begin
                bus_tx <= sh[SH_W-1];
                sh     <= {sh[SH_W-2:0], 1'b0};
                if (arb_left != '0) begin
                  cur_arb  <= 1'b1;
                  arb_left <= arb_left - 1'b1;
                end
                if (cnt == CNT_W'(1)) begin
                  cnt   <= CNT_W'(CRC_W);
                  state <= ST_CRC;
                end else cnt <= cnt - 1'b1;
              end
              ST_CRC: begin
                bus_tx <= crc_msb;
                if (cnt == CNT_W'(1)) state <= ST_CRCDEL;
                else                  cnt   <= cnt - 1'b1;
              end
              ST_CRCDEL: begin bus_tx <= 1'b1; state <= ST_ACK; end
              ST_ACK: begin bus_tx <= 1'b1; cur_ack <= 1'b1; state <= ST_ACKDEL; end
              ST_ACKDEL: begin
                bus_tx <= 1'b1;
                cnt    <= CNT_W'(EOF_BITS);
                state  <= ST_EOF;
              end
              ST_EOF: begin
                bus_tx <= 1'b1;
                if (cnt == CNT_W'(1)) begin
                  cnt   <= CNT_W'(IFS_BITS);
                  state <= ST_IFS;
                end else cnt <= cnt - 1'b1;
              end
              ST_IFS: begin
                bus_tx <= 1'b1;
                if (cnt == CNT_W'(1)) state <= ST_FIN;
                else                  cnt   <= cnt - 1'b1;
              end
              default: begin
                done   <= 1'b1;
                busy   <= 1'b0;
                bus_tx <= 1'b1;
                state  <= ST_IDLE;
              end
            endcase
          end
        end
      end
    end
  end

  assert_idle_recessive_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> bus_tx);
  assert_sof_dominant_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!bus_tx && $past(start) && $past(bit_tick)));
  assert_lost_release_R6: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> (!busy && bus_tx && !done));
  assert_ack_continue_R7: assert property (@(posedge clk) disable iff (rst)
    ack_miss |-> busy);
  assert_done_end_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_tick_only_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_tx) |-> $past(bit_tick));
endmodule

// File: tb/test_can_frame_tx.sv
module test_can_frame_tx;
  localparam int IFS = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0;
  logic        start = 1'b0;
  logic [10:0] ident = '0;
  logic [3:0]  dlc = '0;
  logic [63:0] payload = '0;
  logic        other = 1'b1;
  logic        bus_rx, bus_tx, busy, done, arb_lost, ack_miss;

  assign bus_rx = bus_tx & other;

  can_frame_tx i_can_frame_tx (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start),
    .ident(ident), .dlc(dlc), .payload(payload), .bus_rx(bus_rx),
    .bus_tx(bus_tx), .busy(busy), .done(done),
    .arb_lost(arb_lost), .ack_miss(ack_miss)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic seen_done, seen_lost, seen_ack;
  logic exp_bits [0:199];
  logic oth_bits [0:199];
  int   exp_len, ack_idx;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic step(input logic st);
    @(negedge clk); bit_tick = 1'b1; start = st;
    @(negedge clk); bit_tick = 1'b0; start = 1'b0;
    seen_done = done; seen_lost = arb_lost; seen_ack = ack_miss;
    repeat (2) @(negedge clk);
  endtask

  // Model of R3, R4, R5, R8: fills exp_bits, exp_len, ack_idx
  task automatic build(input logic [10:0] id, input logic [3:0] len, input logic [63:0] pl);
    logic raw [0:114];
    logic [14:0] crc;
    int n, nb, run;
    logic last, fb;
    n = 0;
    raw[n++] = 1'b0;
    for (int i = 10; i >= 0; i--) raw[n++] = id[i];
    for (int i = 0; i < 3; i++) raw[n++] = 1'b0;
    for (int i = 3; i >= 0; i--) raw[n++] = len[i];
    nb = (len > 8) ? 8 : int'(len);
    for (int i = 0; i < 8*nb; i++) raw[n++] = pl[63-i];
    crc = '0;
    for (int i = 0; i < n; i++) begin
      fb = raw[i] ^ crc[14];
      crc = {crc[13:0], 1'b0} ^ (fb ? 15'h4599 : 15'h0);
    end
    for (int i = 14; i >= 0; i--) raw[n++] = crc[i];
    exp_len = 0; run = 0; last = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_bits[exp_len++] = raw[i];
      run = (exp_len > 1 && raw[i] == last) ? run + 1 : 1;
      last = raw[i];
      if (run == 5) begin
        exp_bits[exp_len++] = ~last;
        last = ~last; run = 1;
      end
    end
    exp_bits[exp_len++] = 1'b1;
    ack_idx = exp_len;
    for (int i = 0; i < 2 + 7 + IFS; i++) exp_bits[exp_len++] = 1'b1;
  endtask

  task automatic gap();
    other = 1'b1;
    repeat (IFS) step(1'b0);
  endtask

  task automatic run_frame(input string req, input logic [10:0] id, input logic [3:0] len,
                           input logic [63:0] pl, input bit acked, input bit hold_start,
                           input int stall_at);
    int mism, bad_j, done_j, miss_cnt;
    logic held;
    build(id, len, pl);
    ident = id; dlc = len; payload = pl;
    gap();
    step(1'b1);
    check(busy === 1'b1, {req, " R2 busy after start"}, busy, 1);
    mism = 0; bad_j = -1; done_j = -1; miss_cnt = 0;
    for (int j = 0; j < exp_len; j++) begin
      if (bus_tx !== exp_bits[j]) begin
        mism++;
        if (bad_j < 0) bad_j = j;
      end
      if (j == stall_at) begin
        held = bus_tx;
        repeat (20) @(negedge clk);
        check(bus_tx === held && busy === 1'b1, {req, " R9 hold without strobe"}, bus_tx, held);
      end
      other = (acked && j == ack_idx) ? 1'b0 : 1'b1;
      step(hold_start);
      if (hold_start) begin ident = ~id; dlc = 4'd1; end
      if (seen_ack) miss_cnt++;
      if (seen_done && done_j < 0) done_j = j;
    end
    other = 1'b1;
    check(mism == 0, {req, " R3 R4 R5 wire sequence, first bad bit"}, bad_j, -1);
    check(done_j == exp_len - 1, {req, " R8 done at last gap bit"}, done_j, exp_len - 1);
    check(busy === 1'b0 && bus_tx === 1'b1, {req, " R1 idle after frame"}, busy, 0);
    check(miss_cnt == (acked ? 0 : 1), {req, " R7 ack_miss pulses"}, miss_cnt, acked ? 0 : 1);
  endtask

  task automatic t_reset();
    check(bus_tx === 1'b1, "R1 reset bus_tx", bus_tx, 1);
    check(busy === 1'b0 && done === 1'b0 && arb_lost === 1'b0 && ack_miss === 1'b0,
          "R1 reset flags", busy, 0);
  endtask

  task automatic t_gap();
    int ok_ign;
    ident = 11'h2AA; dlc = 4'd0; payload = '0;
    ok_ign = 1;
    for (int k = 0; k < IFS; k++) begin
      step(1'b1);
      if (busy !== 1'b0 || bus_tx !== 1'b1) ok_ign = 0;
    end
    check(ok_ign == 1, "R2 start ignored before gap complete", busy, 0);
    other = 1'b0; step(1'b0); other = 1'b1;
    step(1'b1);
    check(busy === 1'b0, "R2 dominant bit restarts gap count", busy, 0);
    repeat (IFS - 1) step(1'b0);
    step(1'b1);
    check(busy === 1'b1 && bus_tx === 1'b0, "R2 start accepted after gap", bus_tx, 0);
    build(11'h2AA, 4'd0, '0);
    for (int j = 0; j < exp_len; j++) step(1'b0);
    check(busy === 1'b0, "R8 gap frame completes", busy, 0);
  endtask

  task automatic t_arb();
    int k, lost_j, mism;
    build(11'h122, 4'd1, 64'h5500_0000_0000_0000);
    for (int j = 0; j < exp_len; j++) oth_bits[j] = exp_bits[j];
    build(11'h123, 4'd1, 64'h5500_0000_0000_0000);
    k = -1;
    for (int j = 0; j < exp_len; j++)
      if (k < 0 && exp_bits[j] && !oth_bits[j]) k = j;
    ident = 11'h123; dlc = 4'd1; payload = 64'h5500_0000_0000_0000;
    gap();
    other = oth_bits[0];
    step(1'b1);
    lost_j = -1; mism = 0;
    for (int j = 0; j <= k; j++) begin
      if (bus_tx !== exp_bits[j]) mism++;
      other = oth_bits[j];
      step(1'b0);
      if (seen_lost && lost_j < 0) lost_j = j;
    end
    check(mism == 0, "R6 bits before loss match own frame", mism, 0);
    check(lost_j == k, "R6 arb_lost at losing identifier bit", lost_j, k);
    check(busy === 1'b0 && bus_tx === 1'b1, "R6 released after loss", bus_tx, 1);
    other = 1'b0;
    repeat (4) step(1'b0);
    check(bus_tx === 1'b1 && seen_done === 1'b0, "R6 stays silent, no done", bus_tx, 1);
    other = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gap();
    run_frame("two bytes", 11'h5A5, 4'd2, 64'hC3F0_0000_0000_0000, 1'b1, 1'b0, -1);
    run_frame("zero id no ack", 11'h000, 4'd0, '0, 1'b0, 1'b0, -1);
    run_frame("eight bytes", 11'h7F0, 4'd8, 64'h0011_FFEE_8001_7E00, 1'b1, 1'b0, 9);
    run_frame("length 12 clamp R10 start held", 11'h31C, 4'd12, 64'hFFFF_0000_A5A5_1234,
              1'b1, 1'b1, -1);
    t_arb();
    run_frame("after loss", 11'h001, 4'd3, 64'h0000_00FF_FF00_0000, 1'b1, 1'b0, 30);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule